// File: doc/BRIEF.md
# Two-Clock Relative Frequency Detector

This block ranks two free-running clocks, a write clock and a read clock, after reset. Each clock drives its own race counter that counts a fixed number of its own cycles and then stops. The two finish events are carried into the write-clock domain over two-stage synchronizers. An arbiter there records which one arrives first. The outcome is a single status bit, `wr_faster`, where 1 means the write clock is the faster one and 0 means the read clock is. Equal arrival in the same arbiter cycle counts as a win for the write clock. The bit comes out of reset at 1.

Once the race is decided, software may overwrite the bit through a one-cycle write strobe in the write-clock domain. This covers the case where the clock ratio changes during operation. `busy` is high from reset until the race is decided. Every later change of the bit, whether it comes from the race or from software, raises `busy` again for a fixed settling window. The datapath that uses the result must hold off its accesses while `busy` is high. The ranking is only meaningful when the two frequencies lie within a factor of two of each other.

Top module: `clk_rate_ranker`

## Requirements
- R1: While `rst_n` is low, `wr_faster` is 1 and `busy` is 1.
- R2: After reset, each clock domain counts exactly 1024 rising edges of its own clock, then raises a sticky finish event and stops counting. The race, once decided, is never re-run without a reset.
- R3: When the write clock is clearly faster, `wr_faster` stays 1. `busy` falls in the cycle the race is decided, with no settling window.
- R4: When the read clock is clearly faster, `wr_faster` becomes 0 when the race is decided.
- R5: If both finish events reach the arbiter in the same write-clock cycle, the write clock wins and `wr_faster` is 1. With equal periods and the read edge lagging the write edge by less than half a period, the decision lands on the 1027th write-clock rising edge after reset release. `busy` is seen low after that edge.
- R6: `busy` stays 1 from reset until the race is decided. It never falls while the race is still open.
- R7: Every change of `wr_faster` raises `busy` for exactly 1024 write-clock cycles, counting the cycle that shows the new value.
- R8: After the race is decided, `ovr_we` = 1 with an `ovr_val` that differs from `wr_faster` loads `ovr_val` at the next write-clock edge and starts a settling window.
- R9: An override whose `ovr_val` equals the current bit changes nothing: `wr_faster` keeps its value and `busy` stays 0.
- R10: Any override presented before the race is decided is ignored. This includes an override in the same cycle as the decision.
- R11: An override that changes the bit during a settling window restarts the window, so `busy` lasts 1024 cycles from the newest change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; also the arbiter and register clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ovr_we | input | 1 | Software override strobe (write-clock domain) |
| ovr_val | input | 1 | Override value: 1 write clock faster, 0 read clock faster |
| wr_faster | output | 1 | Ranking result bit, reset value 1 |
| busy | output | 1 | High while racing or settling after a change |

## Verification
Two functions can land in the same write-clock cycle, and the bench provokes both cases deliberately. First, the override port can meet the race decision. The bench holds an override strobe with the losing value through an entire race. The bit must show the race result at the first sample after `busy` falls, before the strobe is dropped. Second, two settling windows can overlap. The bench issues a second changing override 100 cycles into a window, then measures the busy run from the new change and expects the full 1024 cycles again. Exact tie and lead cases use equal periods with fixed phase offsets, so the decision edge can be predicted to the cycle.

// File: rtl/crr_pkg.sv
package crr_pkg;

    typedef enum logic [1:0] {
        ARB_RACE   = 2'd0,
        ARB_SETTLE = 2'd1,
        ARB_IDLE   = 2'd2
    } arb_state_e;

    localparam int unsigned RACE_CNT_W    = 10;
    localparam int unsigned SETTLE_CYCLES = 1024;
    localparam int unsigned SYNC_STAGES   = 2;

endpackage

// File: rtl/crr_race_counter.sv
module crr_race_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LAST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
endmodule

// File: rtl/crr_sync.sv
module crr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = d_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/crr_arbiter.sv
module crr_arbiter
    import crr_pkg::*;
#(
    parameter int unsigned SETTLE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic w_seen_i,
    input  logic r_seen_i,
    input  logic ovr_we_i,
    input  logic ovr_val_i,
    output logic wr_faster_o,
    output logic busy_o,
    output logic resolved_o
);
    localparam int unsigned SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [SW-1:0] LOAD = SW'(SETTLE - 1);

    typedef struct packed {
        arb_state_e    state;
        logic          fast;
        logic [SW-1:0] cnt;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ARB_RACE: begin
                if (w_seen_i || r_seen_i) begin
                    if (w_seen_i != st_q.fast) begin
                        st_d.fast  = w_seen_i;
                        st_d.cnt   = LOAD;
                        st_d.state = ARB_SETTLE;
                    end else begin
                        st_d.state = ARB_IDLE;
                    end
                end
            end
            ARB_SETTLE, ARB_IDLE: begin
                if (ovr_we_i && (ovr_val_i != st_q.fast)) begin
                    st_d.fast  = ovr_val_i;
                    st_d.cnt   = LOAD;
                    st_d.state = ARB_SETTLE;
                end else if (st_q.state == ARB_SETTLE) begin
                    if (st_q.cnt == '0) begin
                        st_d.state = ARB_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            default: st_d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ARB_RACE;
            st_q.fast  <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_faster_o = st_q.fast;
    assign busy_o      = (st_q.state != ARB_IDLE);
    assign resolved_o  = (st_q.state != ARB_RACE);
endmodule

// File: rtl/clk_rate_ranker.sv
module clk_rate_ranker
    import crr_pkg::*;
#(
    parameter int unsigned CNT_W   = RACE_CNT_W,
    parameter int unsigned SETTLE  = SETTLE_CYCLES,
    parameter int unsigned STAGES  = SYNC_STAGES
) (
    input  logic wr_clk,
    input  logic rd_clk,
    input  logic rst_n,
    input  logic ovr_we,
    input  logic ovr_val,
    output logic wr_faster,
    output logic busy
);
    logic w_done, r_done;
    logic w_seen, r_seen;
    logic resolved;

    crr_race_counter #(.CNT_W(CNT_W)) u_wcnt (
        .clk(wr_clk), .rst_n(rst_n), .done_o(w_done)
    );

    crr_race_counter #(.CNT_W(CNT_W)) u_rcnt (
        .clk(rd_clk), .rst_n(rst_n), .done_o(r_done)
    );

    // Local event delayed by the same stage count as the crossing one,
    // so neither side gains a head start at the arbiter.
    crr_sync #(.STAGES(STAGES)) u_wdly (
        .clk(wr_clk), .rst_n(rst_n), .d_i(w_done), .q_o(w_seen)
    );

    crr_sync #(.STAGES(STAGES)) u_rsync (
        .clk(wr_clk), .rst_n(rst_n), .d_i(r_done), .q_o(r_seen)
    );

    crr_arbiter #(.SETTLE(SETTLE)) u_arb (
        .clk(wr_clk), .rst_n(rst_n),
        .w_seen_i(w_seen), .r_seen_i(r_seen),
        .ovr_we_i(ovr_we), .ovr_val_i(ovr_val),
        .wr_faster_o(wr_faster), .busy_o(busy), .resolved_o(resolved)
    );
endmodule

// File: rtl/crr_checks.sv
module crr_checks #(
    parameter int unsigned SETTLE = 1024
) (
    input logic wr_clk,
    input logic rst_n,
    input logic ovr_we,
    input logic wr_faster,
    input logic busy,
    input logic resolved,
    input logic w_seen,
    input logic r_seen
);
    logic prev_q;
    int unsigned run_q;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= 0;
        end else begin
            prev_q <= wr_faster;
            if (wr_faster != prev_q) begin
                run_q <= 1;
            end else if (busy && resolved && run_q < SETTLE + 4) begin
                run_q <= run_q + 1;
            end
        end
    end

    p_busy_while_racing_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !resolved |-> busy);

    p_busy_falls_resolved_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(busy) |-> resolved);

    p_change_sets_busy_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_faster != $past(wr_faster)) |-> busy);

    p_settle_bounded_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        run_q <= SETTLE);

    p_early_ovr_ignored_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!resolved && !w_seen && !r_seen) |=> $stable(wr_faster));

    p_quiet_keeps_bit_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (resolved && !ovr_we) |=> $stable(wr_faster));

    p_decision_sticks_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        resolved |=> resolved);
endmodule

bind clk_rate_ranker crr_checks #(.SETTLE(SETTLE)) u_checks (
    .wr_clk(wr_clk), .rst_n(rst_n), .ovr_we(ovr_we),
    .wr_faster(wr_faster), .busy(busy), .resolved(resolved),
    .w_seen(w_seen), .r_seen(r_seen)
);

// File: tb/clk_rate_ranker_test.sv
`timescale 1ns/1ps
module clk_rate_ranker_test;
    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovr_we = 1'b0;
    logic ovr_val = 1'b0;
    logic wr_faster, busy;

    int pass_n = 0;
    int fail_n = 0;
    bit rd_en = 1'b0;
    real rhalf = 5.0;
    real roff = 0.0;

    clk_rate_ranker uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .ovr_we(ovr_we), .ovr_val(ovr_val),
        .wr_faster(wr_faster), .busy(busy)
    );

    always #5 wr_clk = ~wr_clk;

    always begin
        wait (rd_en);
        #(roff);
        while (rd_en) begin
            #(rhalf) rd_clk = 1'b1;
            #(rhalf) rd_clk = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        if (ok) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_bit(input real rd_half);
        return (rd_half > 5.0) ? 1 : 0;
    endfunction

    task automatic start_race(input real half, input real off, input bit check_rst);
        rst_n = 1'b0;
        rd_en = 1'b0;
        repeat (6) @(negedge wr_clk);
        rhalf = half;
        roff  = off;
        rd_en = 1'b1;
        repeat (3) @(negedge wr_clk);
        if (check_rst) begin
            chk(wr_faster == 1'b1, "R1", "reset bit", int'(wr_faster), 1);
            chk(busy == 1'b1, "R1", "reset busy", int'(busy), 1);
        end
        rst_n = 1'b1;
    endtask

    // Samples after each write edge; k-th sample follows the k-th edge.
    task automatic watch_race(output int fall_n, output int chg_n, output int run);
        fall_n = -1; chg_n = -1; run = 0;
        for (int n = 1; n < 5000; n++) begin
            @(negedge wr_clk);
            if (chg_n < 0 && wr_faster !== 1'b1) chg_n = n;
            if (chg_n >= 0 && busy) run++;
            if (!busy) begin
                fall_n = n;
                break;
            end
        end
    endtask

    task automatic override(input logic v);
        ovr_val = v;
        ovr_we  = 1'b1;
        @(negedge wr_clk);
        ovr_we  = 1'b0;
    endtask

    task automatic count_busy(output int run);
        run = 0;
        while (busy && run < 5000) begin
            run++;
            @(negedge wr_clk);
        end
    endtask

    initial begin
        #1500000;
        fail_n++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

    initial begin
        int fall_n, chg_n, run;
        void'($urandom(32'd4711));

        // R5/R2 tie: equal periods, read edge 3 ns after write edge.
        start_race(5.0, 3.0, 1'b1);
        watch_race(fall_n, chg_n, run);
        chk(wr_faster == 1'b1, "R5", "tie bit", int'(wr_faster), 1);
        chk(fall_n == 1027, "R2", "tie decision edge", fall_n, 1027);
        chk(chg_n == -1, "R6", "tie no change", chg_n, -1);

        // R4/R7: equal periods, read edge 3 ns ahead -> read wins.
        start_race(5.0, 7.0, 1'b0);
        watch_race(fall_n, chg_n, run);
        chk(wr_faster == 1'b0, "R4", "lead bit", int'(wr_faster), 0);
        chk(chg_n == 1026, "R4", "lead change edge", chg_n, 1026);
        chk(run == 1024, "R7", "settle after race", run, 1024);

        // Random clock ratios within the allowed range.
        for (int i = 0; i < 10; i++) begin
            real h;
            real o;
            if ($urandom_range(0, 1) == 0) h = $urandom_range(25, 35) / 10.0;
            else h = $urandom_range(70, 100) / 10.0;
            o = $urandom_range(0, 90) / 10.0;
            start_race(h, o, 1'b1);
            watch_race(fall_n, chg_n, run);
            chk(int'(wr_faster) == exp_bit(h), exp_bit(h) ? "R3" : "R4",
                "random bit", int'(wr_faster), exp_bit(h));
            if (exp_bit(h) == 1)
                chk(fall_n >= 1024 && fall_n <= 1040, "R3", "fast decision",
                    fall_n, 1027);
            else
                chk(run == 1024, "R7", "random settle", run, 1024);
        end

        // R10: override held through the race with the losing value.
        start_race(8.0, 1.0, 1'b0);
        ovr_val = 1'b0;
        ovr_we  = 1'b1;
        watch_race(fall_n, chg_n, run);
        chk(wr_faster == 1'b1, "R10", "override during race", int'(wr_faster), 1);
        chk(chg_n == -1, "R10", "no early change", chg_n, -1);
        ovr_we = 1'b0;
        @(negedge wr_clk);

        // R9: same-value override is a no-op.
        override(1'b1);
        for (int k = 0; k < 3; k++) begin
            chk(busy == 1'b0, "R9", "busy after same write", int'(busy), 0);
            chk(wr_faster == 1'b1, "R9", "bit after same write", int'(wr_faster), 1);
            @(negedge wr_clk);
        end

        // R8: changing override loads value and settles.
        override(1'b0);
        chk(wr_faster == 1'b0, "R8", "override loads", int'(wr_faster), 0);
        count_busy(run);
        chk(run == 1024, "R8", "override settle", run, 1024);

        // R11: second change inside a window restarts it.
        override(1'b1);
        repeat (100) @(negedge wr_clk);
        override(1'b0);
        chk(wr_faster == 1'b0, "R11", "second override", int'(wr_faster), 0);
        count_busy(run);
        chk(run == 1024, "R11", "restarted settle", run, 1024);
        chk(busy == 1'b0, "R7", "idle after settle", int'(busy), 0);

        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end
endmodule